// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers interrupt events for a storage-card host controller into one level-sensitive interrupt line. It keeps a 32-bit raw event register, a 32-bit enable mask, a card-presence status bit and a global control word whose interrupt-enable bit gates the output. Other units of the controller pulse event bits on a set vector. Software reads and clears them through a simple register port, where a write of ones clears the matching bits.

Card insertion and removal are tracked as a pair of mutually exclusive raw flags together with a presence bit in the status register. The interrupt output is registered. It shows the OR of the enabled raw bits one clock after the state that drives it changes.

The register port has a 3-bit select. The codes are: 0 control, 1 mask, 2 masked status, 3 raw status, 4 status. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `card_irq_status_unit`

## Requirements
- R1: After synchronous reset, the control word reads 0x00000300, the mask and raw status read 0, the status register reads 0x00000100 and `irq_o` is low.
- R2: A write to select 0 stores the written value in the control word, except that bits 2, 1 and 0 always read back as 0. A write to select 1 stores the mask.
- R3: `irq_o` is registered. It equals control bit 4 AND the OR of (raw AND mask), sampled one clock after that state is updated.
- R4: While control bit 4 is 0, `irq_o` is low whatever the raw and mask values are.
- R5: Reading select 2 returns raw AND mask. Reading select 3 returns the raw bits unmasked.
- R6: A write to select 2 or select 3 clears every raw bit whose written bit is 1 and leaves every other raw bit unchanged.
- R7: Each bit set on `evt_set_i` sets that raw bit at the next edge. A set and a software clear of the same bit in one cycle leave the bit set.
- R8: A card-insert pulse sets raw bit 30, clears raw bit 31 and sets status bit 8 (presence).
- R9: A card-remove pulse sets raw bit 31, clears raw bit 30 and clears status bit 8. If insert and remove are asserted together, remove takes effect.
- R10: The status register is write-one-to-clear on bit 8, and its other bits read 0. A card event in the same cycle as that write wins over the clear.
- R11: Reads of selects 5 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 32 | Per-bit raw event set pulses from other units |
| card_ins_i | input | 1 | Card inserted event pulse |
| card_rem_i | input | 1 | Card removed event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Registered level interrupt output |

## Verification
A table of enable, event, mask and clear patterns drives the masking path. It separates these cases: a single matched bit, the same bit with the global enable off, events that fall wholly outside the mask, a matched bit in the top position, and partial clears that remove exactly the enabled bit or leave one behind. Each pattern checks the raw read, the masked read and the interrupt output, so a fault in the AND, the OR reduction or the enable gate shows up separately. Directed cases then test the one-cycle lag of the output, the set-over-clear priority, the masked-view clear, card insert and remove and their collision, the status clear racing a card event, the forced-zero control bits and the unused selects.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_MSTAT = 3'd2,
        SEL_RAW   = 3'd3,
        SEL_STAT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic ins;
        logic rem;
    } card_evt_t;

    // true when the event pair carries no card change
    function automatic logic card_idle(input card_evt_t c);
        return !c.ins && !c.rem;
    endfunction

endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
    parameter int              DATA_W   = 32,
    parameter int              IEN_BIT  = 4,
    parameter int              RSTREQ_W = 3,
    parameter logic [DATA_W-1:0] CTRL_RST = 32'h0000_0300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              ien
);
    localparam logic [DATA_W-1:0] REQ_KEEP = ~((DATA_W'(1) << RSTREQ_W) - DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST & REQ_KEEP;
            mask_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata & REQ_KEEP;
            if (mask_we) mask_q <= wdata;
        end
    end

    assign ien = ctrl_q[IEN_BIT];

    // R2: control stores the write with reset-request bits dropped
    a_r2_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_q[DATA_W-1:RSTREQ_W] == $past(wdata[DATA_W-1:RSTREQ_W]))
                    && (ctrl_q[RSTREQ_W-1:0] == '0));
    // R2: mask holds its value unless written
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_raw_status.sv
module irq_raw_status
    import sdirq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int INS_BIT  = 30,
    parameter int REM_BIT  = 31,
    parameter int PRES_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt_set,
    input  card_evt_t         card,
    input  logic              clr_we,
    input  logic              stat_clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw_q,
    output logic              present_q
);
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] raw_nxt;
    logic              pres_nxt;

    always_comb begin
        clr_vec = clr_we ? wdata : '0;
        raw_nxt = (raw_q & ~clr_vec) | evt_set;
        pres_nxt = present_q;
        if (stat_clr_we && wdata[PRES_BIT]) pres_nxt = 1'b0;
        if (card.rem) begin
            raw_nxt[REM_BIT] = 1'b1;
            raw_nxt[INS_BIT] = 1'b0;
            pres_nxt         = 1'b0;
        end else if (card.ins) begin
            raw_nxt[INS_BIT] = 1'b1;
            raw_nxt[REM_BIT] = 1'b0;
            pres_nxt         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            present_q <= 1'b1;
        end else begin
            raw_q     <= raw_nxt;
            present_q <= pres_nxt;
        end
    end

    // R7: an event bit is present after the edge even under a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        card_idle(card) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));
    // R6: cleared bits without a set are gone
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && card_idle(card)) |=> ((raw_q & $past(wdata) & ~$past(evt_set)) == '0));
    // R8: insert marks the card present
    a_r8_insert: assert property (@(posedge clk) disable iff (rst)
        (card.ins && !card.rem) |=> (raw_q[INS_BIT] && !raw_q[REM_BIT] && present_q));
    // R9: remove wins and marks the card absent
    a_r9_remove: assert property (@(posedge clk) disable iff (rst)
        card.rem |=> (raw_q[REM_BIT] && !raw_q[INS_BIT] && !present_q));
    // R10: presence changes only by a status write or a card event
    a_r10_pres_hold: assert property (@(posedge clk) disable iff (rst)
        (card_idle(card) && !stat_clr_we) |=> $stable(present_q));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] mask,
    input  logic              ien,
    output logic [DATA_W-1:0] masked,
    output logic              irq_o
);
    assign masked = raw & mask;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= ien && (|masked);
    end

    // R4: a cleared global enable forces the line low on the next edge
    a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        !ien |=> !irq_o);
    // R3: a pending enabled bit with enable on raises the line one edge later
    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        (ien && ((raw & mask) != '0)) |=> irq_o);
endmodule

// File: rtl/card_irq_status_unit.sv
module card_irq_status_unit
    import sdirq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IEN_BIT  = 4,
    parameter int RSTREQ_W = 3,
    parameter int INS_BIT  = 30,
    parameter int REM_BIT  = 31,
    parameter int PRES_BIT = 8,
    parameter logic [31:0] CTRL_RST = 32'h0000_0300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt_set_i,
    input  logic              card_ins_i,
    input  logic              card_rem_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    card_evt_t         card;
    logic              ctrl_we, mask_we, clr_we, stat_clr_we;
    logic [DATA_W-1:0] ctrl_q, mask_q, raw_q, masked;
    logic              present_q, ien;
    logic [DATA_W-1:0] status_word;

    assign card.ins = card_ins_i;
    assign card.rem = card_rem_i;

    assign ctrl_we     = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign mask_we     = wr_en_i && (wr_sel_i == SEL_MASK);
    assign clr_we      = wr_en_i && ((wr_sel_i == SEL_RAW) || (wr_sel_i == SEL_MSTAT));
    assign stat_clr_we = wr_en_i && (wr_sel_i == SEL_STAT);

    irq_ctrl_regs #(
        .DATA_W(DATA_W), .IEN_BIT(IEN_BIT), .RSTREQ_W(RSTREQ_W),
        .CTRL_RST(CTRL_RST[DATA_W-1:0])
    ) u_ctrl (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .mask_we(mask_we),
        .wdata(wr_data_i), .ctrl_q(ctrl_q), .mask_q(mask_q), .ien(ien)
    );

    irq_raw_status #(
        .DATA_W(DATA_W), .INS_BIT(INS_BIT), .REM_BIT(REM_BIT), .PRES_BIT(PRES_BIT)
    ) u_raw (
        .clk(clk), .rst(rst), .evt_set(evt_set_i), .card(card),
        .clr_we(clr_we), .stat_clr_we(stat_clr_we), .wdata(wr_data_i),
        .raw_q(raw_q), .present_q(present_q)
    );

    irq_out_gen #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .raw(raw_q), .mask(mask_q), .ien(ien),
        .masked(masked), .irq_o(irq_o)
    );

    always_comb begin
        status_word           = '0;
        status_word[PRES_BIT] = present_q;
    end

    always_comb begin
        unique case (rd_sel_i)
            SEL_CTRL:  rd_data_o = ctrl_q;
            SEL_MASK:  rd_data_o = mask_q;
            SEL_MSTAT: rd_data_o = masked;
            SEL_RAW:   rd_data_o = raw_q;
            SEL_STAT:  rd_data_o = status_word;
            default:   rd_data_o = '0;
        endcase
    end

    // R11: writes to unused selects leave the control and mask alone
    a_r11_unused_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_sel_i > SEL_STAT)) |=> ($stable(ctrl_q) && $stable(mask_q)));
endmodule

// File: tb/tb_card_irq_status_unit.sv
module tb_card_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] evt_set_i;
    logic        card_ins_i, card_rem_i, wr_en_i;
    logic [2:0]  wr_sel_i, rd_sel_i;
    logic [31:0] wr_data_i, rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    card_irq_status_unit dut (
        .clk(clk), .rst(rst), .evt_set_i(evt_set_i), .card_ins_i(card_ins_i),
        .card_rem_i(card_rem_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // {ien, events, mask, clear}
    localparam logic [96:0] VEC [0:5] = '{
        {1'b1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
        {1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
        {1'b1, 32'h0000_00F0, 32'h0000_000F, 32'h0000_0000},
        {1'b1, 32'h8000_0010, 32'h8000_0000, 32'h0000_0000},
        {1'b1, 32'h0000_0300, 32'h0000_0100, 32'h0000_0100},
        {1'b1, 32'hFFFF_FFFF, 32'h0000_8000, 32'h7FFF_7FFF}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        rd_sel_i = sel;
        #1;
        v = rd_data_o;
    endtask

    task automatic pulse_evt(input logic [31:0] v);
        evt_set_i = v;
        @(negedge clk);
        evt_set_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; evt_set_i = '0; card_ins_i = 0; card_rem_i = 0;
        wr_en_i = 0; wr_sel_i = '0; wr_data_i = '0; rd_sel_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(3'd0, v); check("R1 ctrl", v, 32'h0000_0300);
        rd(3'd1, v); check("R1 mask", v, 32'h0);
        rd(3'd3, v); check("R1 raw", v, 32'h0);
        rd(3'd4, v); check("R1 status", v, 32'h0000_0100);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 6; i++) begin
            logic        ien;
            logic [31:0] s, m, c, raw_e;
            {ien, s, m, c} = VEC[i];
            raw_e = s & ~c;
            wr(3'd3, 32'hFFFF_FFFF);
            wr(3'd1, m);
            wr(3'd0, ien ? 32'h0000_0310 : 32'h0000_0300);
            pulse_evt(s);
            wr(3'd3, c);
            @(negedge clk);
            rd(3'd3, v); check($sformatf("R6 raw vec%0d", i), v, raw_e);
            rd(3'd2, v); check($sformatf("R5 masked vec%0d", i), v, raw_e & m);
            check($sformatf("R3/R4 irq vec%0d", i), {31'b0, irq_o},
                  {31'b0, ien && ((raw_e & m) != 0)});
        end

        // R2 control write drops reset-request bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 ctrl bits", v, 32'hFFFF_FFF8);
        wr(3'd1, 32'h0000_0020);
        rd(3'd1, v); check("R2 mask", v, 32'h0000_0020);

        // R3 one-cycle lag of irq
        wr(3'd3, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R3 idle irq", {31'b0, irq_o}, 32'h0);
        pulse_evt(32'h0000_0020);
        check("R3 irq before lag", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R3 irq after lag", {31'b0, irq_o}, 32'h1);
        // R4 disable enable
        wr(3'd0, 32'h0000_0300);
        check("R4 irq lag", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R4 irq off", {31'b0, irq_o}, 32'h0);

        // R7 set wins over same-cycle clear
        wr(3'd3, 32'hFFFF_FFFF);
        evt_set_i = 32'h0000_0040;
        wr(3'd3, 32'h0000_0040);
        evt_set_i = '0;
        rd(3'd3, v); check("R7 set wins", v, 32'h0000_0040);

        // R6 clear through masked view
        wr(3'd2, 32'h0000_0040);
        rd(3'd3, v); check("R6 masked-view clear", v, 32'h0);

        // R8 insert
        card_ins_i = 1; @(negedge clk); card_ins_i = 0;
        rd(3'd3, v); check("R8 raw", v, 32'h4000_0000);
        rd(3'd4, v); check("R8 present", v, 32'h0000_0100);
        // R9 remove
        card_rem_i = 1; @(negedge clk); card_rem_i = 0;
        rd(3'd3, v); check("R9 raw", v, 32'h8000_0000);
        rd(3'd4, v); check("R9 absent", v, 32'h0);
        // R9 collision: remove wins
        card_ins_i = 1; @(negedge clk); card_ins_i = 0;
        card_ins_i = 1; card_rem_i = 1; @(negedge clk); card_ins_i = 0; card_rem_i = 0;
        rd(3'd3, v); check("R9 collision raw", v, 32'h8000_0000);
        rd(3'd4, v); check("R9 collision status", v, 32'h0);

        // R10 status write-one-to-clear and race with insert
        card_ins_i = 1;
        wr(3'd4, 32'hFFFF_FFFF);
        card_ins_i = 0;
        rd(3'd4, v); check("R10 insert beats clear", v, 32'h0000_0100);
        wr(3'd4, 32'hFFFF_FEFF);
        rd(3'd4, v); check("R10 zero write keeps", v, 32'h0000_0100);
        wr(3'd4, 32'h0000_0100);
        rd(3'd4, v); check("R10 cleared", v, 32'h0);

        // R11 unused selects
        wr(3'd1, 32'h0000_00FF);
        wr(3'd0, 32'h0000_0310);
        wr(3'd3, 32'hFFFF_FFFF);
        pulse_evt(32'h0000_0003);
        for (int s = 5; s < 8; s++) begin
            wr(3'(s), 32'hFFFF_FFFF);
            rd(3'(s), v); check($sformatf("R11 read sel%0d", s), v, 32'h0);
        end
        rd(3'd0, v); check("R11 ctrl kept", v, 32'h0000_0310);
        rd(3'd1, v); check("R11 mask kept", v, 32'h0000_00FF);
        rd(3'd3, v); check("R11 raw kept", v, 32'h0000_0003);
        check("R11 irq kept", {31'b0, irq_o}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule